// File: doc/BRIEF.md
# Reload Timer with Interrupt Status and Mask Controller

This peripheral sits on a simple synchronous register bus. It pairs a down-counting reload timer with a level interrupt controller. The bus carries a byte address, an access size (byte, halfword or word), write data and a write enable. Read data is combinational from the addressed register. Each cycle in which the `tick` input is high decrements the live count of timer 1. When the decremented value equals the programmed compare value, the counter reloads from its initial value and latches the timer-1 status bit.

The interrupt controller keeps an 18-bit status register and an 18-bit mask register. Software can read and write both. Hardware sources raise status bits through one-cycle set pulses. A single `irq_pending` line is produced for the CPU. It is gated by the CPU's global enable and by the CPU's cause and mask fields. The rest of the timer window (second timer, control words) is plain storage that firmware may use freely.

The block has no internal sequencing states: every register updates in the same cycle as the bus write or tick that affects it.

Top module: `tip_periph`

## Requirements
- R1: Address map by byte offset (bits 1:0 ignored): 0x00 init1, 0x04 compare1, 0x08 init2, 0x0C compare2, 0x10 counter1, 0x14 counter2, 0x18 control1, 0x1C control2, 0x20 status (ISR), 0x24 mask (IMR); all are readable back at those offsets.
- R2: On each cycle with `tick` high, counter1 becomes counter1-1; if that new value equals compare1, counter1 instead takes init1 and ISR bit 14 is set on that same clock edge. The reload period is therefore init1-compare1 ticks.
- R3: A word-size write to init1 also loads counter1 with the same data on the same edge; byte or halfword writes to init1 leave counter1 untouched.
- R4: Size encoding 0 = byte, 1 = halfword, 2 or 3 = word. A byte write replaces bits 7:0 only, a halfword write bits 15:0 only, a word write all 32 bits.
- R5: Reads are masked to the access size: low 8 bits for byte, low 16 bits for halfword, all 32 bits for word.
- R6: ISR and IMR each store 18 bits (write data bits above 17 are dropped, read as zero), are written with the merge rules of R4, and hold their value when not written or set.
- R7: A high bit n on `irq_set` sets ISR bit n on the next edge; bit 14 is also set by timer1 reload (bit 10 is the receive-side source, others per system wiring).
- R8: After reset ISR reads 0x400 (only bit 10 set), IMR reads 0, and all timer registers read 0.
- R9: `irq_pending` is 1 exactly when `cpu_ie` is 1, (`cpu_cause` AND `cpu_imask`) is nonzero and (ISR AND IMR) is nonzero.
- R10: If a set pulse and a software ISR write target the same bit in one cycle, the bit ends up set.
- R11: counter2, init2, compare2 and both control registers change only when written by software.
- R12: Reads at offsets 0x28 to 0x3C return 0 and writes there change no register.
- R13: A software write to counter1 in a cycle with `tick` high wins: counter1 takes the written value and no reload status is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, size-masked |
| tick | input | 1 | Timer advance strobe |
| irq_set | input | 18 | Per-bit status set pulses |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_cause | input | 8 | CPU cause bits |
| cpu_imask | input | 8 | CPU interrupt mask field |
| irq_pending | output | 1 | Gated interrupt request to the CPU |

## Verification
The timer is run with three init/compare pairs, including compare zero and a short period, so an off-by-one reload or a reload on zero shows up as a wrong count at a known tick. Word and sub-word writes to the same register tell apart full replacement from low-byte and low-halfword merging, and a byte write to init1 confirms that only word writes preload the counter. All eight combinations of enable, cause-mask overlap and status-mask overlap are driven to separate each gate of the pending line. Simultaneous set pulse and status clear, and simultaneous tick and counter write, pin down both collision priorities.

// File: rtl/tip_pkg.sv
`timescale 1ns/1ps
package tip_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned TIMER1_BIT  = 14;
    localparam int unsigned RX_BIT      = 10;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    // Merge write data into an existing register according to access size.
    function automatic logic [WORD_W-1:0] merge_sub(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input acc_size_e         sz
    );
        logic [WORD_W-1:0] r;
        unique case (sz)
            SZ_BYTE: r = {old_v[WORD_W-1:8],  new_v[7:0]};
            SZ_HALF: r = {old_v[WORD_W-1:16], new_v[15:0]};
            default: r = new_v;
        endcase
        return r;
    endfunction

    // Mask read data to access size.
    function automatic logic [WORD_W-1:0] size_mask(
        input logic [WORD_W-1:0] v,
        input acc_size_e         sz
    );
        logic [WORD_W-1:0] r;
        unique case (sz)
            SZ_BYTE: r = {{(WORD_W-8){1'b0}},  v[7:0]};
            SZ_HALF: r = {{(WORD_W-16){1'b0}}, v[15:0]};
            default: r = v;
        endcase
        return r;
    endfunction

    function automatic logic is_word(input acc_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_WORD2);
    endfunction

endpackage

// File: rtl/tip_timer.sv
`timescale 1ns/1ps
module tip_timer
    import tip_pkg::*;
#(
    parameter int unsigned NREG = 8,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  acc_size_e         wr_size,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] reg_q [NREG],
    output logic              expire
);
    localparam logic [IDXW-1:0] IDX_INIT1 = IDXW'(0);
    localparam logic [IDXW-1:0] IDX_CMP1  = IDXW'(1);
    localparam logic [IDXW-1:0] IDX_CNT1  = IDXW'(4);
    localparam logic [IDXW-1:0] IDX_CNT2  = IDXW'(5);

    logic [WORD_W-1:0] dec_val;
    logic              preload;
    logic              cnt_wr;
    logic              sw_touch;

    always_comb begin
        dec_val  = reg_q[IDX_CNT1] - WORD_W'(1);
        preload  = wr_en && (wr_idx == IDX_INIT1) && is_word(wr_size);
        cnt_wr   = wr_en && (wr_idx == IDX_CNT1);
        sw_touch = preload || cnt_wr;
        expire   = tick && !sw_touch && (dec_val == reg_q[IDX_CMP1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (IDXW'(i) == IDX_CNT1) begin
                    if (preload)
                        reg_q[i] <= wr_data;
                    else if (cnt_wr)
                        reg_q[i] <= merge_sub(reg_q[i], wr_data, wr_size);
                    else if (tick)
                        reg_q[i] <= expire ? reg_q[IDX_INIT1] : dec_val;
                end else if (wr_en && (wr_idx == IDXW'(i))) begin
                    reg_q[i] <= merge_sub(reg_q[i], wr_data, wr_size);
                end
            end
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_touch) |=>
            ((reg_q[IDX_CNT1] == $past(reg_q[IDX_CNT1]) - WORD_W'(1)) ||
             (reg_q[IDX_CNT1] == $past(reg_q[IDX_INIT1]))));

    // R3
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> (reg_q[IDX_CNT1] == $past(wr_data)));

    // R11
    cnt2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_idx == IDX_CNT2)) |=> $stable(reg_q[IDX_CNT2]));

    // R2
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_touch) |=> $stable(reg_q[IDX_CNT1]));

endmodule

// File: rtl/tip_intc.sv
`timescale 1ns/1ps
module tip_intc
    import tip_pkg::*;
#(
    parameter int unsigned NSRC = 18,
    parameter logic [NSRC-1:0] ISR_RESET = NSRC'(1) << RX_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isr_wr,
    input  logic              imr_wr,
    input  acc_size_e         wr_size,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NSRC-1:0]   set_vec,
    output logic [NSRC-1:0]   isr_q,
    output logic [NSRC-1:0]   imr_q
);
    logic [WORD_W-1:0] isr_merged;
    logic [WORD_W-1:0] imr_merged;
    logic [NSRC-1:0]   isr_d;
    logic              unused_hi;

    always_comb begin
        isr_merged = merge_sub({{(WORD_W-NSRC){1'b0}}, isr_q}, wr_data, wr_size);
        imr_merged = merge_sub({{(WORD_W-NSRC){1'b0}}, imr_q}, wr_data, wr_size);
        isr_d      = (isr_wr ? isr_merged[NSRC-1:0] : isr_q) | set_vec;
    end

    assign unused_hi = ^{isr_merged[WORD_W-1:NSRC], imr_merged[WORD_W-1:NSRC]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= ISR_RESET;
            imr_q <= '0;
        end else begin
            isr_q <= isr_d;
            if (imr_wr) imr_q <= imr_merged[NSRC-1:0];
        end
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((isr_q & $past(set_vec)) == $past(set_vec)));

    // R6
    isr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isr_wr && (set_vec == '0)) |=> $stable(isr_q));

    // R6
    imr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !imr_wr |=> $stable(imr_q));

endmodule

// File: rtl/tip_periph.sv
`timescale 1ns/1ps
module tip_periph
    import tip_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned NSRC      = 18,
    parameter int unsigned CPU_IRQ_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 tick,
    input  logic [NSRC-1:0]      irq_set,
    input  logic                 cpu_ie,
    input  logic [CPU_IRQ_W-1:0] cpu_cause,
    input  logic [CPU_IRQ_W-1:0] cpu_imask,
    output logic                 irq_pending
);
    localparam int unsigned NREG   = 8;
    localparam int unsigned IDXW   = $clog2(NREG);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] WIDX_ISR = WIDX_W'(NREG);
    localparam logic [WIDX_W-1:0] WIDX_IMR = WIDX_W'(NREG + 1);

    acc_size_e          sz;
    logic [WIDX_W-1:0]  widx;
    logic               in_timer;
    logic               tmr_wr;
    logic               isr_wr;
    logic               imr_wr;
    logic               expire;
    logic [WORD_W-1:0]  tmr_q [NREG];
    logic [NSRC-1:0]    isr_q;
    logic [NSRC-1:0]    imr_q;
    logic [NSRC-1:0]    set_vec;
    logic [WORD_W-1:0]  raw_rd;
    logic               unused_lsb;

    assign sz         = acc_size_e'(bus_size);
    assign widx       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];
    assign in_timer   = (widx < WIDX_W'(NREG));
    assign tmr_wr     = bus_we && in_timer;
    assign isr_wr     = bus_we && (widx == WIDX_ISR);
    assign imr_wr     = bus_we && (widx == WIDX_IMR);
    assign set_vec    = irq_set | (NSRC'(expire) << TIMER1_BIT);

    tip_timer #(.NREG(NREG)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (tmr_wr),
        .wr_idx  (widx[IDXW-1:0]),
        .wr_size (sz),
        .wr_data (bus_wdata),
        .reg_q   (tmr_q),
        .expire  (expire)
    );

    tip_intc #(.NSRC(NSRC)) u_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .isr_wr  (isr_wr),
        .imr_wr  (imr_wr),
        .wr_size (sz),
        .wr_data (bus_wdata),
        .set_vec (set_vec),
        .isr_q   (isr_q),
        .imr_q   (imr_q)
    );

    always_comb begin
        if (in_timer)
            raw_rd = tmr_q[widx[IDXW-1:0]];
        else if (widx == WIDX_ISR)
            raw_rd = {{(WORD_W-NSRC){1'b0}}, isr_q};
        else if (widx == WIDX_IMR)
            raw_rd = {{(WORD_W-NSRC){1'b0}}, imr_q};
        else
            raw_rd = '0;
        bus_rdata = size_mask(raw_rd, sz);
    end

    assign irq_pending = cpu_ie && (|(cpu_cause & cpu_imask)) && (|(isr_q & imr_q));

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_timer && (widx != WIDX_ISR) && (widx != WIDX_IMR)) |-> (bus_rdata == '0));

    // R2
    timer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> isr_q[TIMER1_BIT]);

endmodule

// File: tb/tip_periph_tb.sv
`timescale 1ns/1ps
module tip_periph_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 0;
    logic [17:0] irq_set = '0;
    logic        cpu_ie = 0;
    logic [7:0]  cpu_cause = '0;
    logic [7:0]  cpu_imask = '0;
    logic        irq_pending;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    localparam logic [5:0] A_INIT1 = 6'h00, A_CMP1 = 6'h04, A_INIT2 = 6'h08,
                           A_CMP2 = 6'h0C, A_CNT1 = 6'h10, A_CNT2 = 6'h14,
                           A_CTL1 = 6'h18, A_CTL2 = 6'h1C, A_ISR = 6'h20,
                           A_IMR = 6'h24, A_GAP = 6'h28;

    always #2 clk = ~clk;

    tip_periph u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq_set(irq_set), .cpu_ie(cpu_ie), .cpu_cause(cpu_cause),
        .cpu_imask(cpu_imask), .irq_pending(irq_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic brd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_size = sz;
        #0.5 v = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        brd(A_ISR, 2'd2, v);  chk("R8 isr reset", v, 32'h400);
        brd(A_IMR, 2'd2, v);  chk("R8 imr reset", v, 32'h0);
        brd(A_CNT1, 2'd2, v); chk("R8 cnt1 reset", v, 32'h0);
        chk("R9 pending at reset", {31'b0, irq_pending}, 32'h0);
    endtask

    task automatic t_reload(input logic [31:0] init, input logic [31:0] cmp);
        logic [31:0] v;
        int period;
        period = int'(init - cmp);
        bwr(A_CMP1, 2'd2, cmp);
        bwr(A_INIT1, 2'd2, init);
        bwr(A_ISR, 2'd2, 32'h0);
        for (int k = 1; k <= period; k++) begin
            pulse_tick();
            brd(A_CNT1, 2'd2, v);
            chk("R2 counter value", v, (k == period) ? init : init - 32'(k));
            brd(A_ISR, 2'd2, v);
            chk("R2 timer status bit", {31'b0, v[14]}, (k == period) ? 32'h1 : 32'h0);
        end
        brd(A_CMP1, 2'd2, v); chk("R1 compare1 readback", v, cmp);
        brd(A_INIT1, 2'd2, v); chk("R1 init1 readback", v, init);
    endtask

    task automatic t_preload();
        logic [31:0] v;
        bwr(A_INIT1, 2'd2, 32'h0000_1234);
        brd(A_CNT1, 2'd2, v); chk("R3 word preload", v, 32'h0000_1234);
        bwr(A_INIT1, 2'd0, 32'h0000_0055);
        brd(A_CNT1, 2'd2, v); chk("R3 byte no preload", v, 32'h0000_1234);
        brd(A_INIT1, 2'd2, v); chk("R4 init1 byte merge", v, 32'h0000_1255);
    endtask

    task automatic t_merge();
        logic [31:0] v;
        bwr(A_CMP2, 2'd2, 32'hAABB_CCDD);
        bwr(A_CMP2, 2'd0, 32'h1234_5611);
        brd(A_CMP2, 2'd2, v); chk("R4 byte merge", v, 32'hAABB_CC11);
        bwr(A_CMP2, 2'd1, 32'h9999_7777);
        brd(A_CMP2, 2'd2, v); chk("R4 half merge", v, 32'hAABB_7777);
        brd(A_CMP2, 2'd0, v); chk("R5 byte read mask", v, 32'h0000_0077);
        brd(A_CMP2, 2'd1, v); chk("R5 half read mask", v, 32'h0000_7777);
        brd(A_CMP2, 2'd3, v); chk("R5 word read size 3", v, 32'hAABB_7777);
    endtask

    task automatic t_storage();
        logic [31:0] v;
        bwr(A_CNT2, 2'd2, 32'h0000_0777);
        bwr(A_CTL1, 2'd2, 32'hDEAD_0001);
        bwr(A_CTL2, 2'd2, 32'h0BAD_0002);
        bwr(A_INIT2, 2'd2, 32'h0000_0333);
        for (int k = 0; k < 5; k++) pulse_tick();
        brd(A_CNT2, 2'd2, v);  chk("R11 counter2 static", v, 32'h0000_0777);
        brd(A_CTL1, 2'd2, v);  chk("R11 control1 static", v, 32'hDEAD_0001);
        brd(A_CTL2, 2'd2, v);  chk("R11 control2 static", v, 32'h0BAD_0002);
        brd(A_INIT2, 2'd2, v); chk("R11 init2 static", v, 32'h0000_0333);
    endtask

    task automatic t_intc_rw();
        logic [31:0] v;
        bwr(A_IMR, 2'd2, 32'hFFFF_FFFF);
        brd(A_IMR, 2'd2, v); chk("R6 imr 18 bits", v, 32'h0003_FFFF);
        bwr(A_IMR, 2'd0, 32'h0000_0000);
        brd(A_IMR, 2'd2, v); chk("R6 imr byte merge", v, 32'h0003_FF00);
        bwr(A_ISR, 2'd2, 32'h0);
        @(negedge clk); irq_set = 18'h2_0100;
        @(negedge clk); irq_set = '0;
        brd(A_ISR, 2'd2, v); chk("R7 set pulses", v, 32'h0002_0100);
        brd(A_ISR, 2'd2, v); chk("R6 isr holds", v, 32'h0002_0100);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        bwr(A_ISR, 2'd2, 32'h0000_00FF);
        @(negedge clk);
        bus_addr = A_ISR; bus_size = 2'd2; bus_wdata = 32'h0; bus_we = 1;
        irq_set = 18'h0_0020;
        @(negedge clk);
        bus_we = 0; irq_set = '0;
        brd(A_ISR, 2'd2, v); chk("R10 set beats clear", v, 32'h0000_0020);
    endtask

    task automatic t_sw_vs_tick();
        logic [31:0] v;
        bwr(A_CMP1, 2'd2, 32'd99);
        bwr(A_INIT1, 2'd2, 32'd500);
        bwr(A_ISR, 2'd2, 32'h0);
        @(negedge clk);
        bus_addr = A_CNT1; bus_size = 2'd2; bus_wdata = 32'd100; bus_we = 1; tick = 1;
        @(negedge clk);
        bus_we = 0; tick = 0;
        brd(A_CNT1, 2'd2, v); chk("R13 write beats tick", v, 32'd100);
        pulse_tick();
        brd(A_CNT1, 2'd2, v); chk("R13 reload after write", v, 32'd500);
        brd(A_ISR, 2'd2, v);  chk("R13 reload status", v, 32'h0000_4000);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bwr(A_ISR, 2'd2, 32'h0000_0003);
        bwr(A_IMR, 2'd2, 32'h0000_0005);
        bwr(A_GAP, 2'd2, 32'hFFFF_FFFF);
        bwr(6'h3C, 2'd2, 32'hFFFF_FFFF);
        brd(A_GAP, 2'd2, v); chk("R12 unmapped reads zero", v, 32'h0);
        brd(A_ISR, 2'd2, v); chk("R12 isr untouched", v, 32'h3);
        brd(A_IMR, 2'd2, v); chk("R12 imr untouched", v, 32'h5);
    endtask

    task automatic t_pending();
        for (int c = 0; c < 8; c++) begin
            logic e, cm, ii;
            e = c[0]; cm = c[1]; ii = c[2];
            bwr(A_ISR, 2'd2, 32'h0000_0008);
            bwr(A_IMR, 2'd2, ii ? 32'h0000_0008 : 32'h0000_0010);
            @(negedge clk);
            cpu_ie = e; cpu_cause = 8'h04; cpu_imask = cm ? 8'h04 : 8'h08;
            #0.5;
            chk("R9 pending truth table", {31'b0, irq_pending}, {31'b0, e & cm & ii});
        end
        cpu_ie = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_reload(32'd10, 32'd0);
        t_reload(32'd7, 32'd4);
        t_reload(32'd40, 32'd37);
        t_preload();
        t_merge();
        t_storage();
        t_intc_rw();
        t_priority();
        t_sw_vs_tick();
        t_unmapped();
        t_pending();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule